// File: doc/BRIEF.md
# Battery Module Current Loop with PWM Duty Output

This block closes the current loop of a single buck-regulated battery module. A prescaled sample strobe asks the sensing side for a fresh current code. The block subtracts that code from a signed current reference and runs a proportional-integral-derivative law with fixed-point gains. The result is clamped to the duty range and drives an 8-bit pulse-width modulator for the module's switching transistor. A supervisory scheduler reads back the duty value and two saturation flags. It uses them to decide how to move the shared current reference.

Samples enter on a valid/ready stream. The block raises `smp_ready` once per sample period. It holds `smp_ready` high until a sample is transferred, and it drops it the cycle after the transfer. The sender must hold `smp_valid` and `smp_code` until the transfer happens. A sample offered while `smp_ready` is low waits, so back-pressure never loses data. `iref` and `loop_en` are plain control inputs. `iref` is read on the transfer cycle.

Integrator windup is handled by conditional integration. A sample whose unclamped output would land outside the duty range does not update the accumulator. The duty reaches the modulator only at a counter wrap, so no PWM period is cut short.

Top module: `modcur_loop`

## Requirements
- R1: While reset is asserted and just after it is released, `duty` is 0, `pwm_out` is low, `smp_ready` is low, and `full_duty` and `duty_hi` are low.
- R2: `smp_ready` rises TICK_DIV clock edges after reset release, and again once every TICK_DIV cycles. Once high, it stays high until a cycle with `smp_valid` high. That cycle is the transfer, and `smp_ready` is low in the following cycle.
- R3: On a transfer, e = iref − smp_code, where iref is two's complement and smp_code is unsigned. The block forms S = A + e, where A is the accumulator, and u = floor((KP·e + KI·S + KD·(e − e_prev)) / 2^FRAC). The result is visible on `duty` in the cycle after the transfer. e_prev is then set to e. Defaults are KP=256, KI=77, KD=128 and FRAC=8.
- R4: `duty` is u clamped to the range 0..255. A negative u gives 0 and a u above 255 gives 255.
- R5: The accumulator takes the value S only when 0 ≤ u ≤ 255. Otherwise it keeps its old value for that sample.
- R6: While `loop_en` is low, `duty` is 0 from the next cycle, and the accumulator and e_prev are cleared. Transfers still complete but have no effect. After re-enabling, the first sample behaves as if A = 0 and e_prev = 0.
- R7: `full_duty` is high exactly when `duty` = 255. `duty_hi` is high exactly when `duty` ≥ 230.
- R8: The modulator counter advances once every PWM_DIV cycles over 256 steps. In each period `pwm_out` is high for as many steps as the loaded compare value, or for the whole period when that value is 255.
- R9: The compare value is loaded from `duty` only at the counter wrap. Every rising edge of `pwm_out` therefore falls at the same phase of the 256-step period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Loop enable; low forces zero duty and clears loop state |
| iref | input | REF_W (11) | Signed current reference in sensor LSBs |
| smp_valid | input | 1 | Current sample offered |
| smp_ready | output | 1 | Block wants a sample this period |
| smp_code | input | CODE_W (10) | Unsigned current sample code |
| pwm_out | output | 1 | Switch drive |
| duty | output | DUTY_W (8) | Present clamped duty |
| full_duty | output | 1 | Duty at 255 |
| duty_hi | output | 1 | Duty at or above 230 |

## Verification
A wrong accumulator or previous-error value does not show on the sample that corrupts it. It shows on the next accepted sample, as a duty that differs from the one the law predicts. The vector sequence therefore chains samples so that each expected duty depends on the frozen or updated state left by the sample before it. A compare register loaded at the wrong moment shows within one modulator period, as a `pwm_out` rising edge off the period phase. A bad clamp shows in the same cycle as the transfer, through `duty` and the flags.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int DEF_CODE_W   = 10;
  localparam int DEF_REF_W    = 11;
  localparam int DEF_DUTY_W   = 8;
  localparam int DEF_FRAC     = 8;
  localparam int DEF_KP       = 256;   // 1.0
  localparam int DEF_KI       = 77;    // ~0.3
  localparam int DEF_KD       = 128;   // 0.5
  localparam int DEF_ACC_W    = 24;
  localparam int DEF_HI_CODE  = 230;   // ~90 % of full scale
endpackage

// File: rtl/mcl_sampler.sv
module mcl_sampler #(
  parameter int TICK_DIV = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  output logic smp_ready,
  output logic take
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] cnt_q;
  logic          pend_q;
  logic          tick;

  assign tick      = (cnt_q == TW'(TICK_DIV - 1));
  assign smp_ready = pend_q;
  assign take      = pend_q & smp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)      pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
    end
  end

  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !smp_valid) |=> pend_q);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick) |=> !pend_q);
endmodule

// File: rtl/mcl_pid.sv
module mcl_pid #(
  parameter int CODE_W = 10,
  parameter int REF_W  = 11,
  parameter int DUTY_W = 8,
  parameter int FRAC   = 8,
  parameter int KP     = 256,
  parameter int KI     = 77,
  parameter int KD     = 128,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     loop_en,
  input  logic                     take,
  input  logic signed [REF_W-1:0]  iref,
  input  logic [CODE_W-1:0]        code,
  output logic [DUTY_W-1:0]        duty_o
);
  localparam int ERR_W = ((REF_W > CODE_W + 1) ? REF_W : CODE_W + 1) + 1;
  localparam int SUM_W = ACC_W + 32;
  localparam int DMAX  = (1 << DUTY_W) - 1;

  logic signed [ERR_W-1:0] err, eprev_q;
  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic signed [SUM_W-1:0] p_t, i_t, d_t, sum_w, u;
  logic                    over, under, in_range;
  logic [DUTY_W-1:0]       duty_q, duty_nx;

  always_comb begin
    err    = ERR_W'(iref) - ERR_W'($signed({1'b0, code}));
    acc_nx = acc_q + ACC_W'(err);
    p_t    = SUM_W'(err) * SUM_W'(KP);
    i_t    = SUM_W'(acc_nx) * SUM_W'(KI);
    d_t    = (SUM_W'(err) - SUM_W'(eprev_q)) * SUM_W'(KD);
    sum_w  = p_t + i_t + d_t;
    u      = sum_w >>> FRAC;
    under  = u[SUM_W-1];
    over   = !under && (u > SUM_W'(DMAX));
    in_range = !under && !over;
    if (under)     duty_nx = '0;
    else if (over) duty_nx = DUTY_W'(DMAX);
    else           duty_nx = u[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !loop_en) begin
      duty_q  <= '0;
      eprev_q <= '0;
      acc_q   <= '0;
    end else if (take) begin
      duty_q  <= duty_nx;
      eprev_q <= err;
      if (in_range) acc_q <= acc_nx;
    end
  end

  assign duty_o = duty_q;

  assert_duty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !take) |=> $stable(duty_q));
  assert_acc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !take) |=> $stable(acc_q));
  assert_over_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && take && over) |=> (duty_q == DUTY_W'(DMAX)));
  assert_off_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (duty_q == '0 && acc_q == '0 && eprev_q == '0));
endmodule

// File: rtl/mcl_pwm.sv
module mcl_pwm #(
  parameter int DUTY_W  = 8,
  parameter int PWM_DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_o
);
  logic              step, wrap, pwm_q;
  logic [DUTY_W-1:0] cnt_q, cmp_q;

  generate
    if (PWM_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PWM_DIV);
      logic [PW-1:0] pre_q;
      assign step = (pre_q == PW'(PWM_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (step) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign step = 1'b1;
    end
  endgenerate

  assign wrap = step && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (step) cnt_q <= cnt_q + 1'b1;
      if (wrap) cmp_q <= duty;
      pwm_q <= (cmp_q == '1) || (cnt_q < cmp_q);
    end
  end

  assign pwm_o = pwm_q;

  assert_cmp_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_q));
  assert_full_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q == '1) |=> pwm_q);
  assert_zero_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q == '0) |=> !pwm_q);
endmodule

// File: rtl/modcur_loop.sv
module modcur_loop
  import mcl_pkg::*;
#(
  parameter int CODE_W   = DEF_CODE_W,
  parameter int REF_W    = DEF_REF_W,
  parameter int DUTY_W   = DEF_DUTY_W,
  parameter int FRAC     = DEF_FRAC,
  parameter int KP       = DEF_KP,
  parameter int KI       = DEF_KI,
  parameter int KD       = DEF_KD,
  parameter int ACC_W    = DEF_ACC_W,
  parameter int HI_CODE  = DEF_HI_CODE,
  parameter int TICK_DIV = 2_000_000,
  parameter int PWM_DIV  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loop_en,
  input  logic signed [REF_W-1:0] iref,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [CODE_W-1:0]       smp_code,
  output logic                    pwm_out,
  output logic [DUTY_W-1:0]       duty,
  output logic                    full_duty,
  output logic                    duty_hi
);
  logic take;

  mcl_sampler #(.TICK_DIV(TICK_DIV)) u_smp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .take(take)
  );

  mcl_pid #(
    .CODE_W(CODE_W), .REF_W(REF_W), .DUTY_W(DUTY_W), .FRAC(FRAC),
    .KP(KP), .KI(KI), .KD(KD), .ACC_W(ACC_W)
  ) u_pid (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .take(take),
    .iref(iref), .code(smp_code), .duty_o(duty)
  );

  mcl_pwm #(.DUTY_W(DUTY_W), .PWM_DIV(PWM_DIV)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty(duty), .pwm_o(pwm_out)
  );

  assign full_duty = (duty == '1);
  assign duty_hi   = (duty >= DUTY_W'(HI_CODE));

  assert_flag_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_duty |-> duty_hi);
endmodule

// File: tb/modcur_loop_test.sv
module modcur_loop_test;
  localparam int TDIV = 40;
  localparam int NV   = 11;
  // Chained vectors: each expected duty depends on accumulator/previous error left by the one before.
  localparam int V_REF  [NV] = '{100, 100, 200, 300, 150, 150, 330, 330, -50, 0, 121};
  localparam int V_CODE [NV] = '{ 90, 100, 150,   0, 150, 140, 100, 100,   0, 0,   0};
  localparam int V_DUTY [NV] = '{ 18,   0,  93, 255,   0,  36, 255, 255,   0, 46, 238};

  logic clk = 1'b0, rst_n = 1'b0, loop_en = 1'b1, smp_valid = 1'b0;
  logic signed [10:0] iref = '0;
  logic [9:0] smp_code = '0;
  logic smp_ready, pwm_out, full_duty, duty_hi;
  logic [7:0] duty;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modcur_loop #(.TICK_DIV(TDIV), .PWM_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .iref(iref),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_code(smp_code),
    .pwm_out(pwm_out), .duty(duty), .full_duty(full_duty), .duty_hi(duty_hi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int r, input int c);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    iref = 11'(r);
    smp_code = 10'(c);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pwm_measure(input int d);
    int hi = 0;
    int exp = (d == 255) ? 256 : d;
    repeat (512) @(negedge clk);
    repeat (256) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == exp, "R8 pwm high steps", hi, exp);
  endtask

  // R9: rising edges of pwm_out must keep one phase of the 256-step period
  int cyc = 0, phase = -1;
  logic pwm_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pwm_out && !pwm_prev) begin
        if (phase < 0) phase = cyc % 256;
        else chk((cyc % 256) == phase, "R9 pwm rise phase", cyc % 256, phase);
      end
      pwm_prev = pwm_out;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(duty == 0, "R1 duty", duty, 0);
    chk(pwm_out == 0 && smp_ready == 0, "R1 pwm/ready", {pwm_out, smp_ready}, 0);
    chk(full_duty == 0 && duty_hi == 0, "R1 flags", {full_duty, duty_hi}, 0);
    rst_n = 1'b1;

    // R2 first request after TDIV edges
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!smp_ready && n < 1000);
    chk(n == TDIV, "R2 ready period", n, TDIV);
    repeat (100) @(negedge clk);
    chk(smp_ready == 1, "R2 ready held without valid", smp_ready, 1);
    chk(duty == 0, "R1 duty idle after release", duty, 0);
    iref = 11'(100); smp_code = 10'(90); smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    chk(smp_ready == 0, "R2 ready drops after transfer", smp_ready, 0);
    chk(duty == 18, "R3 first sample", duty, 18);

    // re-zero state via disable, then walk the table
    loop_en = 1'b0;
    @(negedge clk);
    loop_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string tag;
      push(V_REF[i], V_CODE[i]);
      if (i == 5 || i == 9)                      tag = "R5 frozen accumulator";
      else if (V_DUTY[i] == 0 || V_DUTY[i] == 255) tag = "R4 clamp";
      else                                          tag = "R3 pid law";
      chk(duty == 8'(V_DUTY[i]), tag, duty, V_DUTY[i]);
      chk(full_duty == (V_DUTY[i] == 255), "R7 full flag", full_duty, int'(V_DUTY[i] == 255));
      chk(duty_hi == (V_DUTY[i] >= 230), "R7 high flag", duty_hi, int'(V_DUTY[i] >= 230));
      if (i == 2 || i == 3 || i == 8) pwm_measure(V_DUTY[i]);
    end

    // R6 disable behaviour
    loop_en = 1'b0;
    @(negedge clk);
    chk(duty == 0, "R6 duty off when disabled", duty, 0);
    push(300, 0);
    chk(duty == 0, "R6 sample ignored when disabled", duty, 0);
    chk(full_duty == 0 && duty_hi == 0, "R6 flags off", {full_duty, duty_hi}, 0);
    loop_en = 1'b1;
    push(100, 90);
    chk(duty == 18, "R6 state cleared on re-enable", duty, 18);
    pwm_measure(18);

    done = 1;
    finish_run();
  end
endmodule